// File: doc/BRIEF.md
# Loss-of-Signal Monitor with Holdover

This block watches an incoming data line for activity, measured against a local reference clock. It raises an alarm once the line has stayed idle for a fixed number of reference clock periods. It drops the alarm again as soon as the line toggles. The data line is asynchronous to the clock. It passes through a synchroniser, and a transition is detected when two successive synchronised samples differ.

A separate holdover select is normally wired to the alarm at integration. While holdover is selected, the block replaces the oscillator control word with a fixed centre-frequency word. It also pins the loop integrator output at mid-scale, so the loop filter cannot wind up while the reference is missing. An output enable acts on four output lanes: main clock, divided clock, recovered clock and retimed data. When the enable is low, every lane is driven low and its tristate request is withdrawn. The oscillator, the analog switching and the pad drivers are outside the block.

Top module: `los_holdover_monitor`

## Requirements
- R1: While reset is asserted, and afterwards until the idle count is reached, `alarm_o` is low.
- R2: Take the rising clock edge that registers a detected transition as the reference edge; it is the third rising edge after `data_i` changes, counting two synchroniser flops. `alarm_o` goes high 256 rising edges after the reference edge, and not one edge earlier.
- R3: A change of `data_i` in either direction clears a high `alarm_o` at the third rising edge after the change. The alarm is still high after the second edge.
- R4: While `data_i` stays idle, `alarm_o` stays high for as long as the idle period lasts. The idle counter saturates at 256 and does not wrap, so there is no false clear.
- R5: With `hold_i` high, `ctrl_word_o` equals the centre word (default 16'h8000), whatever `loop_word_i` is. With `hold_i` low, `ctrl_word_o` equals `loop_word_i`.
- R6: With `hold_i` high, `integ_o` equals mid-scale, which is half of full scale (12'h800 at the default width). With `hold_i` low, `integ_o` equals `integ_i`.
- R7: With `out_en_i` low, every bit of `lanes_o` and `lanes_oe_o` is 0. With `out_en_i` high, `lanes_o` equals `lanes_i` and `lanes_oe_o` is all ones. Lane order from bit 0 up is main, divided, recovered clock, retimed data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local reference clock; its periods are counted |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 1 | Monitored data line, asynchronous |
| hold_i | input | 1 | Holdover select, normally tied to the alarm |
| out_en_i | input | 1 | Global output enable, active high |
| loop_word_i | input | 16 | Oscillator control word from the loop |
| integ_i | input | 12 | Loop integrator value |
| lanes_i | input | 4 | Output lanes before gating |
| alarm_o | output | 1 | Loss-of-signal alarm |
| ctrl_word_o | output | 16 | Oscillator control word after the holdover choice |
| integ_o | output | 12 | Integrator value after the holdover choice |
| lanes_o | output | 4 | Gated output lanes |
| lanes_oe_o | output | 4 | Per-lane drive request; 0 requests high impedance |

## Verification
A wrong idle count shows up only as alarm timing. An off-by-one in the counter or in the synchroniser depth moves the alarm edge by exactly one cycle, about 259 cycles after the last transition. So the bench checks the cycle just before that edge and the edge itself. A counter that wraps instead of saturating would drop the alarm several hundred cycles into a long idle period. A missing counter clear would leave the alarm high at the fourth cycle after a toggle. The holdover and enable paths are combinational, so an error there appears at the ports in the same cycle the select changes.

// File: rtl/los_pkg.sv
package los_pkg;

  // number of gated output lanes: main, divided, recovered clock, retimed data
  localparam int unsigned LANE_COUNT = 4;

  // idle counter width able to hold the limit value itself
  function automatic int unsigned cnt_width(int unsigned limit);
    return $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/los_edge_sync.sv
module los_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic xition_o
);

  // chain_q[STAGES-1] is the synchronised sample, chain_q[STAGES] the previous one
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], din_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign xition_o = chain_q[STAGES] ^ chain_q[STAGES-1];

endmodule

// File: rtl/los_quiet_counter.sv
module los_quiet_counter #(
  parameter int unsigned LIMIT = 256,
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xition_i,
  output logic             alarm_o,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] AT_LIMIT  = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] PRE_LIMIT = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             alarm_q, alarm_d;
  logic             cnt_en;

  // counting stops once the limit is held
  assign cnt_en = (cnt_q != AT_LIMIT);

  always_comb begin
    cnt_d   = cnt_q;
    alarm_d = alarm_q;
    if (xition_i) begin
      cnt_d   = '0;
      alarm_d = 1'b0;
    end else begin
      if (cnt_en) begin
        cnt_d = cnt_q + 1'b1;
      end
      if (cnt_q == PRE_LIMIT) begin
        alarm_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      alarm_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      alarm_q <= alarm_d;
    end
  end

  assign alarm_o = alarm_q;
  assign count_o = cnt_q;

endmodule

// File: rtl/los_hold_mux.sv
module los_hold_mux #(
  parameter int unsigned        CTRL_W      = 16,
  parameter int unsigned        INTEG_W     = 12,
  parameter logic [CTRL_W-1:0]  CTRL_CENTER = 16'h8000
) (
  input  logic               hold_i,
  input  logic [CTRL_W-1:0]  loop_word_i,
  input  logic [INTEG_W-1:0] integ_i,
  output logic [CTRL_W-1:0]  ctrl_word_o,
  output logic [INTEG_W-1:0] integ_o
);

  // half of full scale for the integrator word
  localparam logic [INTEG_W-1:0] INTEG_MID = {1'b1, {(INTEG_W-1){1'b0}}};

  always_comb begin
    if (hold_i) begin
      ctrl_word_o = CTRL_CENTER;
      integ_o     = INTEG_MID;
    end else begin
      ctrl_word_o = loop_word_i;
      integ_o     = integ_i;
    end
  end

endmodule

// File: rtl/los_out_gate.sv
module los_out_gate #(
  parameter int unsigned LANES = 4
) (
  input  logic             en_i,
  input  logic [LANES-1:0] lanes_i,
  output logic [LANES-1:0] lanes_o,
  output logic [LANES-1:0] oe_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes_o[g] = en_i & lanes_i[g];
    assign oe_o[g]    = en_i;
  end

endmodule

// File: rtl/los_holdover_monitor.sv
module los_holdover_monitor #(
  parameter int unsigned       QUIET_LIMIT = 256,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       CTRL_W      = 16,
  parameter int unsigned       INTEG_W     = 12,
  parameter logic [CTRL_W-1:0] CTRL_CENTER = 16'h8000,
  parameter int unsigned       LANES       = los_pkg::LANE_COUNT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               data_i,
  input  logic               hold_i,
  input  logic               out_en_i,
  input  logic [CTRL_W-1:0]  loop_word_i,
  input  logic [INTEG_W-1:0] integ_i,
  input  logic [LANES-1:0]   lanes_i,
  output logic               alarm_o,
  output logic [CTRL_W-1:0]  ctrl_word_o,
  output logic [INTEG_W-1:0] integ_o,
  output logic [LANES-1:0]   lanes_o,
  output logic [LANES-1:0]   lanes_oe_o
);

  localparam int unsigned CNT_W = los_pkg::cnt_width(QUIET_LIMIT);

  logic             det_xition;
  logic [CNT_W-1:0] quiet_cnt;

  los_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .din_i    (data_i),
    .xition_o (det_xition)
  );

  los_quiet_counter #(
    .LIMIT (QUIET_LIMIT),
    .CNT_W (CNT_W)
  ) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .xition_i (det_xition),
    .alarm_o  (alarm_o),
    .count_o  (quiet_cnt)
  );

  los_hold_mux #(
    .CTRL_W      (CTRL_W),
    .INTEG_W     (INTEG_W),
    .CTRL_CENTER (CTRL_CENTER)
  ) u_hold (
    .hold_i      (hold_i),
    .loop_word_i (loop_word_i),
    .integ_i     (integ_i),
    .ctrl_word_o (ctrl_word_o),
    .integ_o     (integ_o)
  );

  los_out_gate #(
    .LANES (LANES)
  ) u_gate (
    .en_i    (out_en_i),
    .lanes_i (lanes_i),
    .lanes_o (lanes_o),
    .oe_o    (lanes_oe_o)
  );

endmodule

// File: rtl/los_holdover_monitor_chk.sv
module los_holdover_monitor_chk #(
  parameter int unsigned       QUIET_LIMIT = 256,
  parameter int unsigned       CNT_W       = 9,
  parameter int unsigned       CTRL_W      = 16,
  parameter int unsigned       INTEG_W     = 12,
  parameter logic [CTRL_W-1:0] CTRL_CENTER = 16'h8000,
  parameter int unsigned       LANES       = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               alarm_i,
  input logic               hold_i,
  input logic               out_en_i,
  input logic [CTRL_W-1:0]  loop_i,
  input logic [CTRL_W-1:0]  ctrl_i,
  input logic [INTEG_W-1:0] integ_i,
  input logic [LANES-1:0]   lanes_in_i,
  input logic [LANES-1:0]   lanes_i,
  input logic [LANES-1:0]   lanes_oe_i,
  input logic               xition_i,
  input logic [CNT_W-1:0]   cnt_i
);

  localparam logic [INTEG_W-1:0] MID = {1'b1, {(INTEG_W-1){1'b0}}};

  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> !alarm_i); // R1

  AST_RISE_ON_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_i) |-> ($past(cnt_i) == CNT_W'(QUIET_LIMIT - 1))); // R2

  AST_CLEAR_ON_XITION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xition_i |=> (!alarm_i && cnt_i == '0)); // R3

  AST_ALARM_AT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_i |-> (cnt_i == CNT_W'(QUIET_LIMIT))); // R4

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_i && !xition_i) |=> alarm_i); // R4

  AST_HOLD_CENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> (ctrl_i == CTRL_CENTER)); // R5

  AST_LOOP_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i |-> (ctrl_i == loop_i)); // R5

  AST_INTEG_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> (integ_i == MID)); // R6

  AST_GATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |-> (lanes_i == '0 && lanes_oe_i == '0)); // R7

  AST_GATE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_i |-> (lanes_i == lanes_in_i && lanes_oe_i == '1)); // R7

endmodule

bind los_holdover_monitor los_holdover_monitor_chk #(
  .QUIET_LIMIT (QUIET_LIMIT),
  .CNT_W       (CNT_W),
  .CTRL_W      (CTRL_W),
  .INTEG_W     (INTEG_W),
  .CTRL_CENTER (CTRL_CENTER),
  .LANES       (LANES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .alarm_i    (alarm_o),
  .hold_i     (hold_i),
  .out_en_i   (out_en_i),
  .loop_i     (loop_word_i),
  .ctrl_i     (ctrl_word_o),
  .integ_i    (integ_o),
  .lanes_in_i (lanes_i),
  .lanes_i    (lanes_o),
  .lanes_oe_i (lanes_oe_o),
  .xition_i   (det_xition),
  .cnt_i      (quiet_cnt)
);

// File: tb/los_holdover_monitor_tb.sv
module los_holdover_monitor_tb;

  localparam int SEL_ALARM = 0;
  localparam int SEL_CTRL  = 1;
  localparam int SEL_INTEG = 2;
  localparam int SEL_LANES = 3;
  localparam int SEL_OE    = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        data_i;
  logic        hold_i;
  logic        out_en_i;
  logic [15:0] loop_word_i;
  logic [11:0] integ_i;
  logic [3:0]  lanes_i;
  logic        alarm_o;
  logic [15:0] ctrl_word_o;
  logic [11:0] integ_o;
  logic [3:0]  lanes_o;
  logic [3:0]  lanes_oe_o;

  typedef struct {
    int          at;
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    cyc    = 0;
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  always #10 clk_i = ~clk_i;

  los_holdover_monitor u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .data_i      (data_i),
    .hold_i      (hold_i),
    .out_en_i    (out_en_i),
    .loop_word_i (loop_word_i),
    .integ_i     (integ_i),
    .lanes_i     (lanes_i),
    .alarm_o     (alarm_o),
    .ctrl_word_o (ctrl_word_o),
    .integ_o     (integ_o),
    .lanes_o     (lanes_o),
    .lanes_oe_o  (lanes_oe_o)
  );

  function automatic logic [31:0] pick(int sel);
    case (sel)
      SEL_ALARM: return {31'd0, alarm_o};
      SEL_CTRL:  return {16'd0, ctrl_word_o};
      SEL_INTEG: return {20'd0, integ_o};
      SEL_LANES: return {28'd0, lanes_o};
      default:   return {28'd0, lanes_oe_o};
    endcase
  endfunction

  // monitor: one sample per falling edge, compares against queued items
  always @(negedge clk_i) begin
    cyc = cyc + 1;
    while (q.size() > 0 && q[0].at <= cyc) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = pick(it.sel);
      n_chk++;
      if (it.at != cyc || act !== it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d cyc=%0d actual=%h expected=%h", it.tag, it.sel, cyc, act, it.exp);
      end
    end
  end

  // driver helpers: inputs change 1 ns after a rising edge
  task automatic tick(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic expect_at(int dly, int sel, logic [31:0] exp, string tag);
    item_t it;
    it.at  = cyc + dly;
    it.sel = sel;
    it.exp = exp;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    rst_ni      = 1'b0;
    data_i      = 1'b0;
    hold_i      = 1'b0;
    out_en_i    = 1'b1;
    loop_word_i = 16'h0000;
    integ_i     = 12'h000;
    lanes_i     = 4'h0;

    // R1: reset state
    tick(3);
    expect_at(1, SEL_ALARM, 32'd0, "R1 reset");
    tick(2);
    rst_ni = 1'b1;
    expect_at(100, SEL_ALARM, 32'd0, "R1 idle below limit");
    tick(110);

    // R2: rising edge of data, alarm exactly 256 edges after the reference edge
    data_i = 1'b1;
    expect_at(4,   SEL_ALARM, 32'd0, "R2 cleared after toggle");
    expect_at(259, SEL_ALARM, 32'd0, "R2 one edge early");
    expect_at(260, SEL_ALARM, 32'd1, "R2 alarm at limit");
    tick(262);

    // R4: long idle, counter must saturate and hold the alarm
    expect_at(1,   SEL_ALARM, 32'd1, "R4 held");
    expect_at(300, SEL_ALARM, 32'd1, "R4 no wrap at 300");
    expect_at(600, SEL_ALARM, 32'd1, "R4 no wrap at 600");
    tick(602);

    // R3: falling data edge while alarm high
    data_i = 1'b0;
    expect_at(3, SEL_ALARM, 32'd1, "R3 still high before detect");
    expect_at(4, SEL_ALARM, 32'd0, "R3 cleared");
    tick(10);

    // R3/R2: periodic activity keeps alarm low, then it returns
    for (int k = 0; k < 4; k++) begin
      data_i = ~data_i;
      expect_at(99, SEL_ALARM, 32'd0, "R3 active line stays clear");
      tick(100);
    end
    data_i = ~data_i;
    expect_at(259, SEL_ALARM, 32'd0, "R2 after bursts early");
    expect_at(260, SEL_ALARM, 32'd1, "R2 after bursts at limit");
    tick(262);

    // R5/R6: holdover multiplexer
    hold_i      = 1'b0;
    loop_word_i = 16'h1234;
    integ_i     = 12'h3AB;
    expect_at(1, SEL_CTRL,  32'h1234, "R5 loop pass");
    expect_at(1, SEL_INTEG, 32'h03AB, "R6 integ pass");
    tick(2);
    hold_i = 1'b1;
    expect_at(1, SEL_CTRL,  32'h8000, "R5 centre word");
    expect_at(1, SEL_INTEG, 32'h0800, "R6 mid scale");
    tick(2);
    loop_word_i = 16'hFFFF;
    integ_i     = 12'h001;
    expect_at(1, SEL_CTRL,  32'h8000, "R5 loop ignored in hold");
    expect_at(1, SEL_INTEG, 32'h0800, "R6 integ ignored in hold");
    tick(2);
    hold_i = 1'b0;
    expect_at(1, SEL_CTRL,  32'hFFFF, "R5 loop restored");
    expect_at(1, SEL_INTEG, 32'h0001, "R6 integ restored");
    tick(2);

    // R7: output enable gating
    lanes_i  = 4'b1010;
    out_en_i = 1'b1;
    expect_at(1, SEL_LANES, 32'hA, "R7 lanes pass");
    expect_at(1, SEL_OE,    32'hF, "R7 drive on");
    tick(2);
    out_en_i = 1'b0;
    expect_at(1, SEL_LANES, 32'h0, "R7 lanes off");
    expect_at(1, SEL_OE,    32'h0, "R7 tristate");
    tick(2);
    lanes_i = 4'b0101;
    expect_at(1, SEL_LANES, 32'h0, "R7 lanes ignored when off");
    expect_at(1, SEL_OE,    32'h0, "R7 still tristate");
    tick(2);
    out_en_i = 1'b1;
    expect_at(1, SEL_LANES, 32'h5, "R7 lanes back");
    expect_at(1, SEL_OE,    32'hF, "R7 drive back");
    tick(3);

    if (q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 scoreboard actual=%0d pending expected=0", q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule